// File: doc/BRIEF.md
# Programmable Three-Phase Wakeup Sequencer

This block sets the timing of a power-up wakeup sequence. The sequence has three phases that run one after another. A single-cycle start pulse begins it. Time is counted from a one-microsecond tick input, and each phase lasts a whole number of ticks. Each phase's length comes from its own 2-bit tap code, and each phase has its own uneven table of four lengths. A global doubling bit doubles all three lengths. In a shortened "buzz" run the third phase is skipped.

Software-facing settings are kept in a held configuration. A write strobe loads that configuration from the setting inputs. The start pulse copies the held configuration, together with the buzz-mode input, into an active snapshot that stays fixed for the whole run. While the sequence runs, the block raises a busy flag. At each phase boundary it gives a one-cycle strobe on the bit for that phase. When the run ends it gives a one-cycle done pulse.

The reset input `rst_n` is taken to be synchronised upstream. It clears the block asynchronously.

Top module: `wake_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `busy`, `phase_end` and `done` are 0. Reset also sets the held configuration to tap codes 11/11/11 with doubling on, so a run started with no prior write lasts 60 + 20 + 20 ticks.
- R2: The first phase lasts 10, 14, 20 or 30 ticks for `tap0` codes 00, 01, 10 and 11.
- R3: The second phase lasts 3, 4, 5 or 10 ticks for `tap1` codes 00, 01, 10 and 11.
- R4: The third phase lasts 1, 2, 5 or 10 ticks for `tap2` codes 00, 01, 10 and 11.
- R5: When the held doubling bit `dbl` is 1, every phase lasts twice its table value.
- R6: When `buzz` is 1 at start, the run ends after the second phase, and `phase_end[2]` never pulses during that run.
- R7: The start pulse samples the held configuration and `buzz`. A `cfg_wr` or a `buzz` change made during a run, or in the same cycle as the start, has no effect on that run.
- R8: A `start` that arrives while `busy` is 1 is ignored. A start accepted while idle raises `busy` in the next cycle.
- R9: When phase k (k = 0, 1, 2) ends, `phase_end[k]` is 1 for exactly one cycle. That cycle follows the clock edge at which the phase's last tick was sampled. At most one strobe bit is set at a time.
- R10: Only ticks sampled while a phase is running count toward it. A tick in the same cycle as the accepted start is not counted.
- R11: `done` pulses for one cycle together with the strobe of the final phase. `busy` is 0 in that same cycle, and a new start may be accepted in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (synchronised upstream) |
| tick_us | input | 1 | One-cycle microsecond tick |
| start | input | 1 | Start pulse |
| buzz | input | 1 | Buzz mode (skip third phase), sampled at start |
| cfg_wr | input | 1 | Loads the held configuration from tap0/tap1/tap2/dbl |
| tap0 | input | 2 | First phase tap code |
| tap1 | input | 2 | Second phase tap code |
| tap2 | input | 2 | Third phase tap code |
| dbl | input | 1 | Doubling bit for all phases |
| busy | output | 1 | Sequence running |
| phase_end | output | 3 | One-cycle phase boundary strobes, bit k = phase k |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench runs every tap code of every phase, with and without doubling, and with tick spacing that is dense, sparse and random. An off-by-one counter or a misplaced table entry shows up as a strobe one tick early or late. The bench also issues a start on the same cycle as a tick and a start on the same cycle as a configuration write. A design that counted the start-cycle tick, or that took the new write, would shorten or reshape that run. Further cases cover a start during a run, a buzz toggle during a run, a start in the cycle that carries `done`, and a reset in the middle of a run. A wrong design would restart, stretch a run, lose the back-to-back start or keep running after reset.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;

  localparam int TAP_W   = 2;
  localparam int N_PHASE = 3;
  localparam int MAX_LEN = 30;
  localparam int CNT_W   = $clog2(2 * MAX_LEN + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_P0   = 2'd1,
    ST_P1   = 2'd2,
    ST_P2   = 2'd3
  } phase_e;

  typedef struct packed {
    logic [TAP_W-1:0] t0;
    logic [TAP_W-1:0] t1;
    logic [TAP_W-1:0] t2;
    logic             dbl;
  } held_cfg_t;

  localparam held_cfg_t CFG_RESET = '{t0: 2'b11, t1: 2'b11, t2: 2'b11, dbl: 1'b1};

  // Base length in ticks for a tap code in a given phase (0..2).
  function automatic logic [CNT_W-1:0] base_len(input int unsigned ph,
                                                input logic [TAP_W-1:0] code);
    logic [CNT_W-1:0] v;
    v = CNT_W'(1);
    unique case (ph)
      0: unique case (code)
           2'b00: v = CNT_W'(10);
           2'b01: v = CNT_W'(14);
           2'b10: v = CNT_W'(20);
           default: v = CNT_W'(30);
         endcase
      1: unique case (code)
           2'b00: v = CNT_W'(3);
           2'b01: v = CNT_W'(4);
           2'b10: v = CNT_W'(5);
           default: v = CNT_W'(10);
         endcase
      default: unique case (code)
           2'b00: v = CNT_W'(1);
           2'b01: v = CNT_W'(2);
           2'b10: v = CNT_W'(5);
           default: v = CNT_W'(10);
         endcase
    endcase
    return v;
  endfunction

endpackage

// File: rtl/wake_seq_cfg.sv
module wake_seq_cfg
  import wake_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  held_cfg_t wr_data,
  input  logic      snap_en,
  input  logic      buzz_in,
  output held_cfg_t act_cfg,
  output logic      act_buzz
);

  held_cfg_t held_q, held_d;
  held_cfg_t act_q, act_d;
  logic      buzz_q, buzz_d;

  always_comb begin
    held_d = held_q;
    act_d  = act_q;
    buzz_d = buzz_q;
    if (wr_en)   held_d = wr_data;
    // Snapshot uses the value held before any same-cycle write.
    if (snap_en) begin
      act_d  = held_q;
      buzz_d = buzz_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= CFG_RESET;
      act_q  <= CFG_RESET;
      buzz_q <= 1'b0;
    end else begin
      held_q <= held_d;
      act_q  <= act_d;
      buzz_q <= buzz_d;
    end
  end

  assign act_cfg  = act_q;
  assign act_buzz = buzz_q;

endmodule

// File: rtl/wake_seq_timer.sv
module wake_seq_timer
  import wake_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] len,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expire = run && tick && (cnt_q == len - CNT_W'(1));
  assign cnt_en = !run || tick;

  always_comb begin
    cnt_d = cnt_q;
    if (!run || expire) cnt_d = '0;
    else if (tick)      cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/wake_seq_ctrl.sv
module wake_seq_ctrl
  import wake_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               expire,
  input  logic               buzz_act,
  output phase_e             state,
  output logic               start_acc,
  output logic [N_PHASE-1:0] strobe,
  output logic               done
);

  phase_e             st_q, st_d;
  logic [N_PHASE-1:0] stb_q, stb_d;
  logic               done_q, done_d;

  assign start_acc = start && (st_q == ST_IDLE);

  always_comb begin
    st_d   = st_q;
    stb_d  = '0;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_acc) st_d = ST_P0;
      ST_P0: if (expire) begin
        stb_d[0] = 1'b1;
        st_d     = ST_P1;
      end
      ST_P1: if (expire) begin
        stb_d[1] = 1'b1;
        if (buzz_act) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          st_d = ST_P2;
        end
      end
      ST_P2: if (expire) begin
        stb_d[2] = 1'b1;
        st_d     = ST_IDLE;
        done_d   = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      stb_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      stb_q  <= stb_d;
      done_q <= done_d;
    end
  end

  assign state  = st_q;
  assign strobe = stb_q;
  assign done   = done_q;

endmodule

// File: rtl/wake_seq.sv
module wake_seq
  import wake_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_us,
  input  logic         start,
  input  logic         buzz,
  input  logic         cfg_wr,
  input  logic [1:0]   tap0,
  input  logic [1:0]   tap1,
  input  logic [1:0]   tap2,
  input  logic         dbl,
  output logic         busy,
  output logic [2:0]   phase_end,
  output logic         done
);

  held_cfg_t          wr_cfg;
  held_cfg_t          act_cfg;
  logic               act_buzz;
  phase_e             state;
  logic               start_acc;
  logic               expire;
  logic               run;
  logic [TAP_W-1:0]   code;
  logic [CNT_W-1:0]   blen;
  logic [CNT_W-1:0]   len;

  assign wr_cfg = '{t0: tap0, t1: tap1, t2: tap2, dbl: dbl};

  wake_seq_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr),
    .wr_data  (wr_cfg),
    .snap_en  (start_acc),
    .buzz_in  (buzz),
    .act_cfg  (act_cfg),
    .act_buzz (act_buzz)
  );

  always_comb begin
    unique case (state)
      ST_P0:   code = act_cfg.t0;
      ST_P1:   code = act_cfg.t1;
      default: code = act_cfg.t2;
    endcase
  end

  assign blen = base_len((state == ST_P0) ? 0 : (state == ST_P1) ? 1 : 2, code);
  assign len  = act_cfg.dbl ? (blen << 1) : blen;
  assign run  = (state != ST_IDLE);

  wake_seq_timer u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .tick   (tick_us),
    .len    (len),
    .expire (expire)
  );

  wake_seq_ctrl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .expire    (expire),
    .buzz_act  (act_buzz),
    .state     (state),
    .start_acc (start_acc),
    .strobe    (phase_end),
    .done      (done)
  );

  assign busy = run;

endmodule

// File: rtl/wake_seq_chk.sv
module wake_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_us,
  input logic       start,
  input logic       busy,
  input logic [2:0] phase_end,
  input logic       done
);

  // R9
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phase_end));

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R11
  last_strobe_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_end[2] |-> done);

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(start) && !$past(busy)));

  // R10
  no_tick_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_us || !busy) |=> (phase_end == 3'b000 && !done));

  // R9
  mid_strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_end[0] || (phase_end[1] && !done)) |-> busy);

endmodule

bind wake_seq wake_seq_chk u_wake_seq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_us   (tick_us),
  .start     (start),
  .busy      (busy),
  .phase_end (phase_end),
  .done      (done)
);

// File: tb/wake_seq_test.sv
module wake_seq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_us = 1'b0;
  logic       start = 1'b0;
  logic       buzz = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] tap0 = 2'b00;
  logic [1:0] tap1 = 2'b00;
  logic [1:0] tap2 = 2'b00;
  logic       dbl = 1'b0;
  logic       busy;
  logic [2:0] phase_end;
  logic       done;

  always #2 clk = ~clk;

  wake_seq uut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .start(start), .buzz(buzz),
    .cfg_wr(cfg_wr), .tap0(tap0), .tap1(tap1), .tap2(tap2), .dbl(dbl),
    .busy(busy), .phase_end(phase_end), .done(done)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  int tick_mode = 0;
  int cyc = 0;

  // Reference model
  int len0[4] = '{10, 14, 20, 30};
  int len1[4] = '{3, 4, 5, 10};
  int len2[4] = '{1, 2, 5, 10};
  int rem[$];
  int ph_idx = 0;
  int h0 = 3, h1 = 3, h2 = 3;
  bit hd = 1'b1;
  bit       exp_busy = 1'b0;
  bit [2:0] exp_stb = 3'b000;
  bit       exp_done = 1'b0;

  always @(posedge clk) begin
    int m;
    exp_stb  = 3'b000;
    exp_done = 1'b0;
    if (!rst_n) begin
      rem.delete();
      ph_idx = 0;
      h0 = 3; h1 = 3; h2 = 3; hd = 1'b1;
    end else begin
      if (rem.size() == 0) begin
        if (start) begin
          m = hd ? 2 : 1;
          rem.push_back(len0[h0] * m);
          rem.push_back(len1[h1] * m);
          if (!buzz) rem.push_back(len2[h2] * m);
          ph_idx = 0;
        end
      end else if (tick_us) begin
        rem[0] = rem[0] - 1;
        if (rem[0] == 0) begin
          void'(rem.pop_front());
          exp_stb[ph_idx] = 1'b1;
          ph_idx++;
          if (rem.size() == 0) exp_done = 1'b1;
        end
      end
      if (cfg_wr) begin
        h0 = tap0; h1 = tap1; h2 = tap2; hd = dbl;
      end
    end
    exp_busy = (rem.size() != 0);
  end

  task automatic check(input bit ok, input string t, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", t, what, cyc, act, exp);
    end
  endtask

  // Compare then drive tick, away from the active edge
  always @(negedge clk) begin
    cyc++;
    check(busy == exp_busy, tag, "busy", busy, exp_busy);
    check(phase_end == exp_stb, tag, "phase_end", phase_end, exp_stb);
    check(done == exp_done, tag, "done", done, exp_done);
    case (tick_mode)
      0: tick_us = 1'b1;
      1: tick_us = (cyc % 2 == 0);
      2: tick_us = ($urandom_range(0, 1) == 1);
      default: tick_us = (cyc % 5 == 0);
    endcase
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual %0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_cfg(input int a, input int b, input int c, input bit d);
    @(negedge clk);
    tap0 = 2'(a); tap1 = 2'(b); tap2 = 2'(c); dbl = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_start(input bit bz);
    @(negedge clk);
    start = 1'b1; buzz = bz;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    idle(2);
  endtask

  initial begin
    // R1: reset state and default held configuration
    tag = "R1";
    idle(3);
    check(busy == 1'b0 && phase_end == 3'b000 && done == 1'b0, "R1", "reset outputs",
          {busy, phase_end, done}, 0);
    rst_n = 1'b1;
    idle(2);
    pulse_start(1'b0);
    wait_idle();

    // R2, R3, R4: every code of every phase, no doubling
    tick_mode = 1;
    for (int c = 0; c < 4; c++) begin
      tag = (c % 3 == 0) ? "R2" : (c % 3 == 1) ? "R3" : "R4";
      write_cfg(c, c, c, 1'b0);
      pulse_start(1'b0);
      wait_idle();
      write_cfg(c, 3 - c, (c + 1) % 4, 1'b0);
      pulse_start(1'b0);
      wait_idle();
    end

    // R5: doubling
    tag = "R5";
    tick_mode = 0;
    for (int c = 0; c < 4; c++) begin
      write_cfg(c, (c + 2) % 4, 3 - c, 1'b1);
      pulse_start(1'b0);
      wait_idle();
    end

    // R6: buzz mode skips third phase
    tag = "R6";
    tick_mode = 2;
    write_cfg(1, 2, 3, 1'b0);
    pulse_start(1'b1);
    wait_idle();
    write_cfg(0, 0, 0, 1'b1);
    pulse_start(1'b1);
    wait_idle();

    // R7: writes and buzz changes during run, and write in start cycle
    tag = "R7";
    tick_mode = 1;
    write_cfg(0, 0, 0, 1'b0);
    @(negedge clk);
    start = 1'b1; buzz = 1'b0;
    tap0 = 2'd3; tap1 = 2'd3; tap2 = 2'd3; dbl = 1'b1; cfg_wr = 1'b1;
    @(negedge clk);
    start = 1'b0; cfg_wr = 1'b0; buzz = 1'b1;
    idle(5);
    write_cfg(2, 1, 1, 1'b0);
    wait_idle();
    buzz = 1'b0;
    pulse_start(1'b0);
    wait_idle();

    // R8: start while busy ignored
    tag = "R8";
    tick_mode = 0;
    write_cfg(1, 1, 1, 1'b0);
    pulse_start(1'b0);
    idle(4);
    pulse_start(1'b1);
    idle(10);
    pulse_start(1'b0);
    wait_idle();

    // R10: sparse ticks and tick in the start cycle
    tag = "R10";
    tick_mode = 3;
    write_cfg(0, 0, 1, 1'b0);
    for (int k = 0; k < 5; k++) begin
      idle(k);
      pulse_start(1'b0);
      wait_idle();
    end

    // R11: start in the done cycle (back-to-back)
    tag = "R11";
    tick_mode = 0;
    write_cfg(0, 0, 0, 1'b0);
    pulse_start(1'b0);
    @(negedge clk);
    while (!done) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();

    // R9: strobe timing under random ticks, all modes
    tag = "R9";
    tick_mode = 2;
    write_cfg(2, 3, 2, 1'b1);
    pulse_start(1'b0);
    wait_idle();

    // R1: reset in mid-run returns to idle
    tag = "R1";
    write_cfg(3, 3, 3, 1'b0);
    pulse_start(1'b0);
    idle(15);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && phase_end == 3'b000 && done == 1'b0, "R1", "mid-run reset",
          {busy, phase_end, done}, 0);
    rst_n = 1'b1;
    idle(2);
    tick_mode = 0;
    pulse_start(1'b0);
    wait_idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule